// File: doc/BRIEF.md
# Transfer Count and Activation Enable Unit

This unit keeps the transfer counters and the per-source activation enables of a small data mover that interrupts trigger. A host port writes and reads three registers: a 16-bit count A, a 16-bit block count B, and an 8-bit enable register with one bit for each interrupt source. The surrounding mover raises `done_valid` with the source number each time it has moved one data unit. The unit then steps the counters in the way the selected mode asks for, flags the end of the programmed sequence, and decides whether the CPU still gets an interrupt. It also drops the enable bit of that source when it is finished with it.

Count A has two meanings. In normal mode it is one 16-bit down-counter. In repeat and block modes its high byte holds a reload value and its low byte counts down, reloading from the high byte when a run is finished. In block mode count B counts finished blocks, and the sequence ends when B runs out. A loaded value of zero stands for the full range of the counter (65536 or 256).

Top module: `xfer_count_ctrl`

## Requirements
- R1: After reset, count A, count B and the enable register read 0, and `end_pulse` and `cpu_irq` are 0.
- R2: `host_addr` 0 selects count A, 1 selects count B and 2 selects the enable register (bits 7:0, upper read bits 0). Address 3 reads 0. A write takes effect at the clock edge, and `host_rdata` shows the selected register combinationally.
- R3: The mode encoding is 0 normal, 1 repeat, 2 block, and 3 acts as normal. In normal mode each accepted transfer decrements A by 1. A transfer with A at 1 ends the sequence. A transfer with A at 0 leaves 0xFFFF and does not end it.
- R4: In repeat mode each accepted transfer decrements the low byte of A, and a low byte of 0 counts as 256. A transfer with the low byte at 1 loads the low byte from the high byte. The high byte never changes, and the sequence never ends.
- R5: In block mode A steps as in R4. B decrements only on a transfer that reloads the low byte. The sequence ends on the transfer that reloads the low byte while B is 1, so a run takes low + (B-1)*high transfers.
- R6: `end_pulse` and `cpu_irq` are registered and high for the single cycle after an accepted transfer. `end_pulse` is high when that transfer ended the sequence. `cpu_irq` is high when it ended the sequence or when `disable_sel` was 1.
- R7: When `cpu_irq` is raised, the enable bit of that source is cleared at the same edge. All other enable bits, and that bit when no interrupt is raised, keep their values.
- R8: A transfer whose source enable bit is 0 is ignored: the counters do not change and no pulse is raised.
- R9: When a host write and a transfer arrive in the same cycle, the write applies and the whole transfer update is dropped: no count step, no pulse and no enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected register |
| mode | input | 2 | 0 normal, 1 repeat, 2 block, 3 normal |
| disable_sel | input | 1 | Raise CPU interrupt and clear enable after every transfer |
| done_valid | input | 1 | One data unit was moved |
| done_src | input | 3 | Source number of that transfer |
| end_pulse | output | 1 | Programmed sequence has ended |
| cpu_irq | output | 1 | CPU interrupt request pulse |
| enable_bits | output | 8 | Current activation enables |

## Verification
A wrong count or a bad reload shows up on `host_rdata` as soon as the register is read after the transfer. It also shows up as an `end_pulse` one transfer early or late, one cycle after the transfer that should have ended the run. A wrong enable state appears on `enable_bits` in the cycle after the transfer. When the enable state is wrong, later transfers from that source are taken or refused in error, and the counts then stop moving or keep moving when they should not. The block-mode sweep compares the exact transfer count at which the sequence ends against low + (B-1)*high. It therefore catches a B that steps per data unit rather than per block.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_ALT    = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    REG_CNT_A  = 2'd0,
    REG_CNT_B  = 2'd1,
    REG_ENABLE = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xcc_step_a.sv
module xcc_step_a #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic         split,
  output logic [W-1:0] nxt,
  output logic         lo_wrap,
  output logic         full_end
);
  localparam int H = W / 2;

  function automatic logic [H-1:0] step_lo(input logic [H-1:0] lo, input logic [H-1:0] hi);
    return (lo == H'(1)) ? hi : lo - H'(1);
  endfunction

  function automatic logic [W-1:0] step_full(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  logic [H-1:0] lo_part, hi_part;
  assign lo_part  = cnt[H-1:0];
  assign hi_part  = cnt[W-1:H];
  assign lo_wrap  = (lo_part == H'(1));
  assign full_end = (cnt == W'(1));
  assign nxt      = split ? {hi_part, step_lo(lo_part, hi_part)} : step_full(cnt);
endmodule

// File: rtl/xcc_step_b.sv
module xcc_step_b #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic         take,
  output logic [W-1:0] nxt,
  output logic         last
);
  function automatic logic [W-1:0] dec(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  assign nxt  = take ? dec(cnt) : cnt;
  assign last = take && (cnt == W'(1));
endmodule

// File: rtl/xcc_enable.sv
module xcc_enable #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [N-1:0]  wr_bits,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  bits
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bits[i] <= 1'b0;
      else if (wr_en)                            bits[i] <= wr_bits[i];
      else if (clr_en && (clr_idx == IW'(i)))    bits[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl #(
  parameter int CNT_W = 16,
  parameter int SRC_N = 8,
  localparam int SRC_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rdata,
  input  logic [1:0]       mode,
  input  logic             disable_sel,
  input  logic             done_valid,
  input  logic [SRC_W-1:0] done_src,
  output logic             end_pulse,
  output logic             cpu_irq,
  output logic [SRC_N-1:0] enable_bits
);
  import xcc_pkg::*;

  xfer_mode_e mode_e;
  reg_sel_e   sel_e;
  assign mode_e = xfer_mode_e'(mode);
  assign sel_e  = reg_sel_e'(host_addr);

  logic [CNT_W-1:0] cnt_a, cnt_b, a_nxt, b_nxt;
  logic             split, is_block, lo_wrap, full_end, b_last;

  // named internal events
  logic fire, ended, raise;

  assign split    = (mode_e == MODE_REPEAT) || (mode_e == MODE_BLOCK);
  assign is_block = (mode_e == MODE_BLOCK);

  xcc_step_a #(.W(CNT_W)) u_step_a (
    .cnt(cnt_a), .split(split), .nxt(a_nxt), .lo_wrap(lo_wrap), .full_end(full_end)
  );

  xcc_step_b #(.W(CNT_W)) u_step_b (
    .cnt(cnt_b), .take(is_block && lo_wrap), .nxt(b_nxt), .last(b_last)
  );

  assign fire  = done_valid && !host_we && enable_bits[done_src];
  assign ended = is_block ? b_last : (!split && full_end);
  assign raise = ended || disable_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      if (host_we && sel_e == REG_CNT_A) cnt_a <= host_wdata;
      else if (fire)                     cnt_a <= a_nxt;
      if (host_we && sel_e == REG_CNT_B) cnt_b <= host_wdata;
      else if (fire)                     cnt_b <= b_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_pulse <= 1'b0;
      cpu_irq   <= 1'b0;
    end else begin
      end_pulse <= fire && ended;
      cpu_irq   <= fire && raise;
    end
  end

  xcc_enable #(.N(SRC_N)) u_enable (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(host_we && sel_e == REG_ENABLE),
    .wr_bits(host_wdata[SRC_N-1:0]),
    .clr_en(fire && raise),
    .clr_idx(done_src),
    .bits(enable_bits)
  );

  always_comb begin
    unique case (sel_e)
      REG_CNT_A:  host_rdata = cnt_a;
      REG_CNT_B:  host_rdata = cnt_b;
      REG_ENABLE: host_rdata = CNT_W'(enable_bits);
      default:    host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xcc_checker.sv
module xcc_checker #(
  parameter int CNT_W = 16,
  parameter int SRC_N = 8,
  localparam int SRC_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic [1:0]       mode,
  input logic             done_valid,
  input logic [SRC_W-1:0] done_src,
  input logic             end_pulse,
  input logic             cpu_irq,
  input logic [SRC_N-1:0] enable_bits,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b
);
  AST_END_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> cpu_irq); // R6
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse); // R6
  AST_IRQ_NEEDS_CLEAN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(done_valid && !host_we)); // R9
  AST_IRQ_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !enable_bits[$past(done_src)]); // R7
  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_we) |-> ((enable_bits & ~$past(enable_bits)) == '0)); // R7
  AST_REPEAT_NEVER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> ($past(mode) != 2'd1)); // R4
  AST_IDLE_HOLDS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(done_valid) && !$past(host_we)) |-> $stable(cnt_a)); // R8
  AST_B_ONLY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(host_we) && $past(mode) != 2'd2) |-> $stable(cnt_b)); // R5
endmodule

bind xfer_count_ctrl xcc_checker #(.CNT_W(CNT_W), .SRC_N(SRC_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .mode(mode),
  .done_valid(done_valid), .done_src(done_src), .end_pulse(end_pulse),
  .cpu_irq(cpu_irq), .enable_bits(enable_bits), .cnt_a(cnt_a), .cnt_b(cnt_b)
);

// File: tb/xfer_count_ctrl_test.sv
`timescale 1ns/1ps
module xfer_count_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [1:0]  mode = 2'd0;
  logic        disable_sel = 1'b0;
  logic        done_valid = 1'b0;
  logic [2:0]  done_src = '0;
  logic        end_pulse, cpu_irq;
  logic [7:0]  enable_bits;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_count_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mode(mode),
    .disable_sel(disable_sel), .done_valid(done_valid), .done_src(done_src),
    .end_pulse(end_pulse), .cpu_irq(cpu_irq), .enable_bits(enable_bits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    host_addr = a; #1;
    d = host_rdata;
  endtask

  // one transfer; ep/irq sampled in the cycle after the accepting edge
  task automatic xfer(input logic [2:0] src, output logic ep, output logic irq);
    @(negedge clk);
    done_valid = 1'b1; done_src = src;
    @(posedge clk); #1;
    done_valid = 1'b0;
    ep = end_pulse; irq = cpu_irq;
  endtask

  function automatic int eff(input int v, input int full);
    return (v == 0) ? full : v;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic ep, irq;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 cntA", d, 0);
    rd(2'd1, d); chk("R1 cntB", d, 0);
    rd(2'd2, d); chk("R1 enable", d, 0);
    chk("R1 pulses", {end_pulse, cpu_irq}, 0);

    // R2 register map
    wr(2'd0, 16'hA5C3); wr(2'd1, 16'h1E2F); wr(2'd2, 16'hFF96);
    rd(2'd0, d); chk("R2 A", d, 16'hA5C3);
    rd(2'd1, d); chk("R2 B", d, 16'h1E2F);
    rd(2'd2, d); chk("R2 enable", d, 16'h0096);
    rd(2'd3, d); chk("R2 addr3", d, 0);

    // R3 normal mode sweep, counts 1..6
    mode = 2'd0;
    for (int n = 1; n <= 6; n++) begin
      wr(2'd2, 16'(1 << (n % 8)));
      wr(2'd0, 16'(n));
      for (int t = 1; t <= n; t++) begin
        xfer(3'(n % 8), ep, irq);
        rd(2'd0, d); chk("R3 normal count", d, 16'(n - t));
        chk("R3 normal end", ep, (t == n));
        chk("R6 irq on end", irq, (t == n));
      end
      chk("R7 cleared at end", enable_bits, 0);
    end
    // R6 single-cycle pulse
    @(posedge clk); #1;
    chk("R6 pulse drops", {end_pulse, cpu_irq}, 0);

    // R3 zero means full range; mode 3 acts as normal
    wr(2'd2, 16'h0001); wr(2'd0, 16'h0000);
    xfer(3'd0, ep, irq);
    rd(2'd0, d); chk("R3 zero wraps", d, 16'hFFFF);
    chk("R3 no end from zero", {ep, irq}, 0);
    chk("R7 bit kept", enable_bits, 8'h01);
    mode = 2'd3; wr(2'd0, 16'h0001);
    xfer(3'd0, ep, irq);
    chk("R3 mode3 ends", ep, 1);

    // R6/R7 disable_sel: irq without end, only that bit cleared
    mode = 2'd0; disable_sel = 1'b1;
    wr(2'd2, 16'h00FF); wr(2'd0, 16'h0005);
    xfer(3'd3, ep, irq);
    chk("R6 disable_sel irq", {ep, irq}, 2'b01);
    chk("R7 only src bit cleared", enable_bits, 8'hF7);
    rd(2'd0, d); chk("R3 step with disable_sel", d, 16'h0004);

    // R8 disabled source ignored
    xfer(3'd3, ep, irq);
    rd(2'd0, d); chk("R8 count held", d, 16'h0004);
    chk("R8 no pulse", {ep, irq}, 0);

    // R9 host write wins over transfer
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'd0; host_wdata = 16'h1234;
    done_valid = 1'b1; done_src = 3'd1;
    @(posedge clk); #1;
    host_we = 1'b0; done_valid = 1'b0;
    chk("R9 no pulse", {end_pulse, cpu_irq}, 0);
    rd(2'd0, d); chk("R9 write applied", d, 16'h1234);
    chk("R9 enable kept", enable_bits, 8'hF7);
    disable_sel = 1'b0;

    // R4 repeat mode: several reload/low pairs, never ends
    mode = 2'd1;
    for (int h = 1; h <= 3; h++) begin
      for (int l = 1; l <= 3; l++) begin
        wr(2'd2, 16'h0004);
        wr(2'd0, 16'((h << 8) | l));
        for (int k = 1; k <= 8; k++) begin
          int e;
          xfer(3'd2, ep, irq);
          e = (k < l) ? (l - k) : (h - ((k - l) % h));
          rd(2'd0, d); chk("R4 repeat value", d, 16'((h << 8) | e));
          chk("R4 repeat no end", {ep, irq}, 0);
        end
        chk("R4 enable kept", enable_bits, 8'h04);
      end
    end
    // R4 low byte 0 counts as 256
    wr(2'd0, 16'h0300);
    xfer(3'd2, ep, irq);
    rd(2'd0, d); chk("R4 low zero", d, 16'h03FF);

    // R5 block mode: end after low + (B-1)*high transfers
    mode = 2'd2;
    for (int l = 1; l <= 3; l++) begin
      for (int h = 1; h <= 3; h++) begin
        for (int nb = 1; nb <= 3; nb++) begin
          int total;
          int s;
          s = (l + h + nb) % 8;
          total = l + (nb - 1) * h;
          wr(2'd2, 16'(1 << s));
          wr(2'd0, 16'((h << 8) | l));
          wr(2'd1, 16'(nb));
          for (int t = 1; t <= total; t++) begin
            xfer(3'(s), ep, irq);
            chk("R5 block end timing", {ep, irq}, (t == total) ? 2'b11 : 2'b00);
          end
          rd(2'd1, d); chk("R5 B exhausted", d, 0);
          rd(2'd0, d); chk("R5 A reloaded", d, 16'((h << 8) | h));
          chk("R7 block clears", enable_bits, 0);
        end
      end
    end
    // R5 B steps once per block, not per data unit
    wr(2'd2, 16'h0001); wr(2'd0, 16'h0203); wr(2'd1, 16'h0000);
    for (int t = 1; t <= 5; t++) xfer(3'd0, ep, irq);
    rd(2'd1, d); chk("R5 B per block", d, 16'hFFFE);
    rd(2'd0, d); chk("R5 A after blocks", d, {8'h02, 8'(eff(2, 256))});

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule